// File: doc/BRIEF.md
# Byte-Wide UART Register Front End

This block is the register file and interrupt logic that a host processor sees when it talks to a 16450-class serial port that has no FIFOs. It sits on an 8-entry byte bus, with a 3-bit offset, a write strobe and a read strobe. It feeds a separate serial engine, which does the bit shifting and runs the baud counter. For transmission it presents one held byte with a valid level and waits for a done pulse. For reception the engine hands over one byte or a break indication with a single strobe.

The block holds the line control register, which sets the word length, drives the break output and switches offsets 0 and 1 over to a 16-bit divisor latch. It also holds the interrupt enables, the modem control bits, a scratch byte and the line status flags. The interrupt output follows a two-level priority: received data ranks above the transmit-empty event. The transmit-empty event is remembered in an internal pending flag, and a read of the identification register clears that flag when the read reports it. A loopback bit redirects the modem control outputs into the modem status read value.

Top module: `uart_regif`

## Requirements
- R1: After reset the line status register (offset 5) reads 0x60, the identification register (offset 2) reads 0x01, `irq_o` is low and `tx_valid_o` is low.
- R2: When line control bit 7 is 1, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8, and `divisor_o` shows the latch. When that bit is 0, offset 1 reads and writes the interrupt enables in bits 3:0, and bits 7:4 read as 0.
- R3: Offset 2 reads 0x04 when data ready (status bit 0) and enable bit 0 are both set. Failing that, it reads 0x02 when the transmit pending flag and enable bit 1 are both set. Otherwise it reads 0x01.
- R4: `irq_o` is high exactly when the identification value is not 0x01.
- R5: A write to offset 0 with line control bit 7 clear loads `tx_data_o`, raises `tx_valid_o` and clears status bits 5 and 6. A `tx_done_i` pulse sets both bits again, drops `tx_valid_o` and sets the transmit pending flag.
- R6: A read of offset 2 that returns 0x02 clears the transmit pending flag.
- R7: A write to the enable register while status bit 5 is set sets the transmit pending flag.
- R8: A read of offset 0 with line control bit 7 clear returns the received byte and clears status bits 0 and 4.
- R9: A strobe that carries the break flag sets status bits 4 and 0 and makes the received byte read as 0x00, whatever the state of data ready.
- R10: A data byte is stored and data ready is set only when data ready was clear. Otherwise the byte is discarded, the stored byte is kept and status bit 1 is set. A read of offset 5 clears bit 1.
- R11: Offset 6 reads {`dcd_i`, `ri_i`, `dsr_i`, `cts_i`, 0000} when modem control bit 4 is clear. When that bit is set, it reads modem control bit 3 in bit 7, bit 2 in bit 6, bit 0 in bit 5 and bit 1 in bit 4, with the low nibble 0. Modem control bits 0..3 drive `dtr_o`, `rts_o`, `out1_o` and `out2_o`.
- R12: Line control bit 6 drives `brk_o`, and `data_bits_o` equals line control bits 1:0 plus 5.
- R13: Offset 7 is a scratch byte that reads back what was written. Writes to offsets 2, 5 and 6 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; side effects take place at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset (combinational) |
| irq_o | output | 1 | Interrupt request |
| tx_data_o | output | 8 | Byte handed to the serial engine |
| tx_valid_o | output | 1 | High while a byte waits for the engine |
| tx_done_i | input | 1 | Engine finished the byte (one-cycle pulse) |
| rx_strobe_i | input | 1 | Engine delivers a byte or a break |
| rx_break_i | input | 1 | Qualifies the strobe as a break |
| rx_data_i | input | 8 | Received byte |
| dtr_o | output | 1 | Modem control bit 0 |
| rts_o | output | 1 | Modem control bit 1 |
| out1_o | output | 1 | Modem control bit 2 |
| out2_o | output | 1 | Modem control bit 3 |
| cts_i | input | 1 | Modem status input |
| dsr_i | input | 1 | Modem status input |
| ri_i | input | 1 | Modem status input |
| dcd_i | input | 1 | Modem status input |
| brk_o | output | 1 | Break control to the line |
| divisor_o | output | 16 | Baud divisor for the engine |
| data_bits_o | output | 4 | Word length in bits (5..8) |

## Verification
The assertions rely on the engine raising `tx_done_i` only while `tx_valid_o` is high. They also rely on one bus strobe per cycle at most, and on no receive strobe arriving in the same cycle as a read of offsets 0 or 5, since simultaneous clear and set events would blur the cycle after. The stimulus keeps to these rules by construction. Each operation is a single-cycle pulse separated from the next. The random sequence issues a done pulse only when its model shows a byte outstanding, and every other choice becomes a transmit write instead. Enable values, received bytes and breaks are drawn at random, so data ready, overrun and the pending flag meet in every combination.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int DIV_W  = 16;
  localparam int IEN_W  = 4;
  localparam int MCR_W  = 5;

  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_ID   = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_LCTL = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_MCTL = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_LSTA = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_MSTA = 3'd6;
  localparam logic [ADDR_W-1:0] OFS_SCR  = 3'd7;

  localparam logic [DATA_W-1:0] ID_NONE  = 8'h01;
  localparam logic [DATA_W-1:0] ID_TXEMP = 8'h02;
  localparam logic [DATA_W-1:0] ID_RXRDY = 8'h04;

  typedef struct packed {
    logic temt;
    logic thre;
    logic bi;
    logic oe;
    logic dr;
  } line_stat_t;

  // priority encoder of the identification value
  function automatic logic [DATA_W-1:0] id_code(input logic rx_int, input logic tx_int);
    if (rx_int)      return ID_RXRDY;
    else if (tx_int) return ID_TXEMP;
    else             return ID_NONE;
  endfunction

  // status flags placed at their bit positions
  function automatic logic [DATA_W-1:0] lsta_pack(input line_stat_t s);
    return {1'b0, s.temt, s.thre, s.bi, 2'b00, s.oe, s.dr};
  endfunction

  // modem status view; pins = {dcd, ri, dsr, cts}
  function automatic logic [DATA_W-1:0] msta_view(input logic [MCR_W-1:0] mc,
                                                   input logic [3:0] pins);
    if (mc[4]) return {mc[3], mc[2], mc[0], mc[1], 4'b0000};
    else       return {pins, 4'b0000};
  endfunction

  function automatic logic [3:0] word_bits(input logic [1:0] wl);
    return 4'd5 + {2'b00, wl};
  endfunction

endpackage

// File: rtl/uart_regif_line.sv
module uart_regif_line
  import uart_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              thr_wr,
  input  logic              rbr_rd,
  input  logic              lsta_rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tx_done,
  input  logic              rx_strobe,
  input  logic              rx_break,
  input  logic [DATA_W-1:0] rx_data,
  output line_stat_t        stat,
  output logic [DATA_W-1:0] rbr,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_valid
);

  logic rx_brk_evt, rx_take, rx_drop;

  assign rx_brk_evt = rx_strobe && rx_break;
  assign rx_take    = rx_strobe && !rx_break && !stat.dr;
  assign rx_drop    = rx_strobe && !rx_break && stat.dr;
  assign tx_valid   = !stat.thre;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat    <= '{temt: 1'b1, thre: 1'b1, default: 1'b0};
      rbr     <= '0;
      tx_data <= '0;
    end else begin
      if (thr_wr) begin
        tx_data   <= wdata;
        stat.thre <= 1'b0;
        stat.temt <= 1'b0;
      end
      if (tx_done) begin
        stat.thre <= 1'b1;
        stat.temt <= 1'b1;
      end
      if (rbr_rd) begin
        stat.dr <= 1'b0;
        stat.bi <= 1'b0;
      end
      if (lsta_rd) stat.oe <= 1'b0;
      if (rx_brk_evt) begin
        rbr     <= '0;
        stat.bi <= 1'b1;
        stat.dr <= 1'b1;
      end else if (rx_take) begin
        rbr     <= rx_data;
        stat.dr <= 1'b1;
      end else if (rx_drop) begin
        stat.oe <= 1'b1;
      end
    end
  end

  AST_THR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr && !tx_done |=> tx_valid && !stat.temt); // R5
  AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> stat.thre && stat.temt); // R5
  AST_RBR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rbr_rd && !rx_strobe |=> !stat.dr && !stat.bi); // R8
  AST_BREAK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_brk_evt |=> stat.bi && stat.dr && (rbr == '0)); // R9
  AST_DROP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> stat.oe && $stable(rbr)); // R10
  AST_TAKE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_take |=> stat.dr && (rbr == $past(rx_data))); // R10

endmodule

// File: rtl/uart_regif_irq.sv
module uart_regif_irq
  import uart_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dr,
  input  logic              thre,
  input  logic              en_rx,
  input  logic              en_tx,
  input  logic              ien_wr,
  input  logic              id_rd,
  input  logic              tx_done,
  output logic [DATA_W-1:0] id_val,
  output logic              irq,
  output logic              tx_pend
);

  logic pend_set, pend_clr;

  assign id_val   = id_code(dr && en_rx, tx_pend && en_tx);
  assign irq      = (id_val != ID_NONE);
  assign pend_set = tx_done || (ien_wr && thre);
  assign pend_clr = id_rd && (id_val == ID_TXEMP);

  always_ff @(posedge clk) begin
    if (!rst_n)        tx_pend <= 1'b0;
    else if (pend_set) tx_pend <= 1'b1;
    else if (pend_clr) tx_pend <= 1'b0;
  end

  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr && !tx_done && !(ien_wr && thre) |=> !tx_pend); // R6
  AST_PEND_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    ien_wr && thre |=> tx_pend); // R7
  AST_RX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    dr && en_rx |-> irq && (id_val == ID_RXRDY)); // R3

endmodule

// File: rtl/uart_regif_modem.sv
module uart_regif_modem
  import uart_regif_pkg::*;
(
  input  logic [MCR_W-1:0]  mctl,
  input  logic              cts,
  input  logic              dsr,
  input  logic              ri,
  input  logic              dcd,
  output logic [DATA_W-1:0] msta,
  output logic              dtr,
  output logic              rts,
  output logic              out1,
  output logic              out2
);

  assign msta = msta_view(mctl, {dcd, ri, dsr, cts});
  assign dtr  = mctl[0];
  assign rts  = mctl[1];
  assign out1 = mctl[2];
  assign out2 = mctl[3];

endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter logic [DIV_W-1:0] DIV_RESET = 16'd12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_done_i,
  input  logic              rx_strobe_i,
  input  logic              rx_break_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              dtr_o,
  output logic              rts_o,
  output logic              out1_o,
  output logic              out2_o,
  input  logic              cts_i,
  input  logic              dsr_i,
  input  logic              ri_i,
  input  logic              dcd_i,
  output logic              brk_o,
  output logic [DIV_W-1:0]  divisor_o,
  output logic [3:0]        data_bits_o
);

  localparam int HALF = DIV_W / 2;

  logic [DATA_W-1:0] lctl_q, scr_q, rbr, id_val, msta;
  logic [IEN_W-1:0]  ien_q;
  logic [MCR_W-1:0]  mctl_q;
  logic [DIV_W-1:0]  div_q;
  line_stat_t        stat;
  logic              tx_pend, dlab;
  logic              wr_thr, wr_dll, wr_dlm, wr_ien, rd_rbr, rd_id, rd_lsta;

  assign dlab    = lctl_q[7];
  assign wr_thr  = bus_wr && (bus_addr == OFS_DATA) && !dlab;
  assign wr_dll  = bus_wr && (bus_addr == OFS_DATA) && dlab;
  assign wr_ien  = bus_wr && (bus_addr == OFS_IEN)  && !dlab;
  assign wr_dlm  = bus_wr && (bus_addr == OFS_IEN)  && dlab;
  assign rd_rbr  = bus_rd && (bus_addr == OFS_DATA) && !dlab;
  assign rd_id   = bus_rd && (bus_addr == OFS_ID);
  assign rd_lsta = bus_rd && (bus_addr == OFS_LSTA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lctl_q <= '0;
      scr_q  <= '0;
      ien_q  <= '0;
      mctl_q <= '0;
      div_q  <= DIV_RESET;
    end else begin
      if (wr_dll) div_q[HALF-1:0]     <= bus_wdata;
      if (wr_dlm) div_q[DIV_W-1:HALF] <= bus_wdata;
      if (wr_ien) ien_q <= bus_wdata[IEN_W-1:0];
      if (bus_wr && (bus_addr == OFS_LCTL)) lctl_q <= bus_wdata;
      if (bus_wr && (bus_addr == OFS_MCTL)) mctl_q <= bus_wdata[MCR_W-1:0];
      if (bus_wr && (bus_addr == OFS_SCR))  scr_q  <= bus_wdata;
    end
  end

  uart_regif_line u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .thr_wr   (wr_thr),
    .rbr_rd   (rd_rbr),
    .lsta_rd  (rd_lsta),
    .wdata    (bus_wdata),
    .tx_done  (tx_done_i),
    .rx_strobe(rx_strobe_i),
    .rx_break (rx_break_i),
    .rx_data  (rx_data_i),
    .stat     (stat),
    .rbr      (rbr),
    .tx_data  (tx_data_o),
    .tx_valid (tx_valid_o)
  );

  uart_regif_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .dr     (stat.dr),
    .thre   (stat.thre),
    .en_rx  (ien_q[0]),
    .en_tx  (ien_q[1]),
    .ien_wr (wr_ien),
    .id_rd  (rd_id),
    .tx_done(tx_done_i),
    .id_val (id_val),
    .irq    (irq_o),
    .tx_pend(tx_pend)
  );

  uart_regif_modem u_modem (
    .mctl(mctl_q),
    .cts (cts_i),
    .dsr (dsr_i),
    .ri  (ri_i),
    .dcd (dcd_i),
    .msta(msta),
    .dtr (dtr_o),
    .rts (rts_o),
    .out1(out1_o),
    .out2(out2_o)
  );

  always_comb begin
    case (bus_addr)
      OFS_DATA: bus_rdata = dlab ? div_q[HALF-1:0] : rbr;
      OFS_IEN:  bus_rdata = dlab ? div_q[DIV_W-1:HALF] : {{(DATA_W-IEN_W){1'b0}}, ien_q};
      OFS_ID:   bus_rdata = id_val;
      OFS_LCTL: bus_rdata = lctl_q;
      OFS_MCTL: bus_rdata = {{(DATA_W-MCR_W){1'b0}}, mctl_q};
      OFS_LSTA: bus_rdata = lsta_pack(stat);
      OFS_MSTA: bus_rdata = msta;
      default:  bus_rdata = scr_q;
    endcase
  end

  assign brk_o       = lctl_q[6];
  assign divisor_o   = div_q;
  assign data_bits_o = word_bits(lctl_q[1:0]);

  AST_DIV_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dll |=> divisor_o[HALF-1:0] == $past(bus_wdata)); // R2
  AST_IRQ_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ien_q[0] || ien_q[1])); // R4
  AST_PEND_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pend && ien_q[1] |-> irq_o); // R4

endmodule

// File: tb/uart_regif_bench.sv
module uart_regif_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        bwr = 1'b0, brd = 1'b0;
  logic [7:0]  wdata = '0, rdata;
  logic        irq, tx_valid, tx_done = 1'b0;
  logic [7:0]  tx_data;
  logic        rx_stb = 1'b0, rx_brk = 1'b0;
  logic [7:0]  rx_dat = '0;
  logic        dtr, rts, out1, out2, brk;
  logic        cts = 1'b0, dsr = 1'b1, ri = 1'b0, dcd = 1'b1;
  logic [15:0] divisor;
  logic [3:0]  dbits;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic       m_dr = 0, m_bi = 0, m_oe = 0, m_thre = 1, m_temt = 1, m_pend = 0;
  logic [3:0] m_ien = '0;
  logic [7:0] m_rbr = '0;

  always #4 clk = ~clk;

  uart_regif u_uart_regif (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(bwr), .bus_rd(brd),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq), .tx_data_o(tx_data),
    .tx_valid_o(tx_valid), .tx_done_i(tx_done), .rx_strobe_i(rx_stb),
    .rx_break_i(rx_brk), .rx_data_i(rx_dat), .dtr_o(dtr), .rts_o(rts),
    .out1_o(out1), .out2_o(out2), .cts_i(cts), .dsr_i(dsr), .ri_i(ri),
    .dcd_i(dcd), .brk_o(brk), .divisor_o(divisor), .data_bits_o(dbits)
  );

  function automatic logic [7:0] exp_id();
    if (m_dr && m_ien[0])        return 8'h04;
    else if (m_pend && m_ien[1]) return 8'h02;
    else                         return 8'h01;
  endfunction

  function automatic logic [7:0] exp_lsta();
    return {1'b0, m_temt, m_thre, m_bi, 2'b00, m_oe, m_dr};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%04h expected=%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; bwr = 1'b1;
    @(negedge clk); bwr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; brd = 1'b1;
    #1 d = rdata;
    @(negedge clk); brd = 1'b0;
  endtask

  task automatic chk_irq();
    chk("R4 irq", {15'b0, irq}, {15'b0, exp_id() != 8'h01});
  endtask

  task automatic op_ien(input logic [7:0] v);
    wr(3'd1, v);
    m_ien = v[3:0];
    if (m_thre) m_pend = 1'b1;   // R7
    chk_irq();
  endtask

  task automatic op_id();
    logic [7:0] d, e;
    e = exp_id();
    rd(3'd2, d);
    chk("R3 id", {8'b0, d}, {8'b0, e});
    if (e == 8'h02) m_pend = 1'b0; // R6
    chk_irq();
  endtask

  task automatic op_thr(input logic [7:0] v);
    wr(3'd0, v);
    m_thre = 1'b0; m_temt = 1'b0;
    chk("R5 tx_data", {8'b0, tx_data}, {8'b0, v});
    chk("R5 tx_valid", {15'b0, tx_valid}, 16'd1);
    chk_irq();
  endtask

  task automatic op_done();
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
    m_thre = 1'b1; m_temt = 1'b1; m_pend = 1'b1;
    chk("R5 tx_valid low", {15'b0, tx_valid}, 16'd0);
    chk_irq();
  endtask

  task automatic op_rx(input logic brk_f, input logic [7:0] v);
    @(negedge clk); rx_stb = 1'b1; rx_brk = brk_f; rx_dat = v;
    @(negedge clk); rx_stb = 1'b0; rx_brk = 1'b0;
    if (brk_f) begin m_rbr = 8'h00; m_bi = 1'b1; m_dr = 1'b1; end  // R9
    else if (!m_dr) begin m_rbr = v; m_dr = 1'b1; end               // R10
    else m_oe = 1'b1;
    chk_irq();
  endtask

  task automatic op_rbr();
    logic [7:0] d;
    rd(3'd0, d);
    chk("R8 rbr", {8'b0, d}, {8'b0, m_rbr});
    m_dr = 1'b0; m_bi = 1'b0;
    chk_irq();
  endtask

  task automatic op_lsta();
    logic [7:0] d;
    rd(3'd5, d);
    chk("R10 lsta", {8'b0, d}, {8'b0, exp_lsta()});
    m_oe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int unsigned seed;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd5, d); chk("R1 lsta", {8'b0, d}, 16'h0060);
    rd(3'd2, d); chk("R1 id", {8'b0, d}, 16'h0001);
    chk("R1 irq", {15'b0, irq}, 16'd0);
    chk("R1 tx_valid", {15'b0, tx_valid}, 16'd0);

    // R2 divisor latch
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h34);
    wr(3'd1, 8'h12);
    chk("R2 divisor", divisor, 16'h1234);
    rd(3'd0, d); chk("R2 dll", {8'b0, d}, 16'h0034);
    rd(3'd1, d); chk("R2 dlm", {8'b0, d}, 16'h0012);
    chk("R2 no tx", {15'b0, tx_valid}, 16'd0);
    wr(3'd3, 8'h03);
    rd(3'd1, d); chk("R2 ien view", {8'b0, d}, 16'h0000);

    // R12 line control outputs
    chk("R12 bits8", {12'b0, dbits}, 16'd8);
    wr(3'd3, 8'h40);
    chk("R12 brk", {15'b0, brk}, 16'd1);
    chk("R12 bits5", {12'b0, dbits}, 16'd5);
    wr(3'd3, 8'h02);
    chk("R12 bits7", {12'b0, dbits}, 16'd7);
    chk("R12 brk off", {15'b0, brk}, 16'd0);

    // R13 scratch and ignored offsets
    wr(3'd7, 8'hA5);
    rd(3'd7, d); chk("R13 scr", {8'b0, d}, 16'h00A5);
    wr(3'd5, 8'hFF); wr(3'd2, 8'hFF); wr(3'd6, 8'hFF);
    rd(3'd5, d); chk("R13 lsta kept", {8'b0, d}, 16'h0060);
    rd(3'd2, d); chk("R13 id kept", {8'b0, d}, 16'h0001);
    rd(3'd6, d); chk("R13 msta kept", {8'b0, d}, 16'h00A0);

    // R11 modem lines
    rd(3'd6, d); chk("R11 pins", {8'b0, d}, 16'h00A0);
    wr(3'd4, 8'h03);
    chk("R11 dtr rts", {14'b0, rts, dtr}, 16'd3);
    wr(3'd4, 8'h15);
    rd(3'd6, d); chk("R11 loop out1 dtr", {8'b0, d}, 16'h0060);
    wr(3'd4, 8'h1A);
    rd(3'd6, d); chk("R11 loop out2 rts", {8'b0, d}, 16'h0090);
    chk("R11 out pins", {14'b0, out2, out1}, 16'd2);
    wr(3'd4, 8'h00);

    // R7 / R6 directed
    op_ien(8'h02);
    op_id();
    op_id();
    // R3 priority: data ready ranks first
    op_ien(8'h03);
    op_rx(1'b0, 8'h5A);
    op_id();
    op_rx(1'b0, 8'hC3);      // R10 overrun
    op_lsta();
    op_lsta();
    op_rbr();
    op_id();
    op_rx(1'b1, 8'h77);      // R9 break
    op_lsta();
    op_rbr();
    op_thr(8'h9E);
    op_lsta();
    op_done();
    op_id();

    // random phase
    seed = $urandom(32'd20240611);
    for (int i = 0; i < 600; i++) begin
      case ($urandom_range(0, 7))
        0: op_ien(8'($urandom));
        1: op_id();
        2: op_rx(1'b0, 8'($urandom));
        3: op_rx(($urandom_range(0, 3) == 0), 8'($urandom));
        4: op_rbr();
        5: op_lsta();
        6: if (!m_thre) op_done(); else op_thr(8'($urandom));
        default: begin
          rd(3'd1, d);
          chk("R2 ien read", {8'b0, d}, {12'b0, m_ien});
        end
      endcase
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule